// File: doc/BRIEF.md
# Decode-Stage Hazard Scoreboard

This block decides, cycle by cycle, whether the instruction waiting at the decode stage of a single-issue pipeline may issue. It keeps one small countdown per architectural register. When an instruction that writes a register issues, that register's countdown is loaded with the instruction's extra result latency. Each countdown then steps down once per cycle, and a nonzero count marks the register's result as not yet available. A second set of countdowns, one per instruction class, tracks how long a multicycle execution unit stays occupied after it accepts an instruction.

The decode stage presents the two source indices, the destination index, a write flag, a class code, a latency code and an issue-interval code, together with a valid bit. The block answers in the same cycle with a stall flag and an issue pulse. An instruction stalls only if it actually reads a pending register or needs a unit that is still occupied. Independent instructions therefore keep issuing while long-latency results are outstanding, and a true consumer waits exactly the remaining latency. While stalled, decode holds its inputs. Forwarding paths and the execution units themselves lie outside this block.

Top module: `hazard_scoreboard`

## Requirements
- R1: After reset no register and no class is pending, so the first valid instruction issues in the cycle it is presented, whatever it reads.
- R2: `out_stall` is high only while `in_valid` is high, and `out_issue` equals `in_valid` AND NOT `out_stall` in the same cycle, with no register between them.
- R3: An issued write with latency code 0 creates no hazard: an instruction that reads its destination in the very next cycle issues without stalling.
- R4: An issued write of latency L > 0 to register d makes a reader of d presented k cycles later (k >= 1) stall for max(0, L - k + 1) cycles. A reader presented right after issue therefore stalls L cycles, and a latency-2 result with two independent instructions in between causes no stall.
- R5: Register index 0 is never pending. Writes to it are not tracked, and reading it never stalls.
- R6: A pending register stalls the reader whether it appears as source A or as source B.
- R7: Instructions whose sources are not pending, and whose class is not occupied, issue back to back while other results are still outstanding.
- R8: Issuing an instruction of class c with interval code I > 0 makes the next instruction of class c stall until I cycles after that issue. Instructions of other classes are not affected.
- R9: A stalled instruction loads no countdown. Its own latency starts counting from the cycle it actually issues.
- R10: A newer issued write to a register replaces its countdown with the new latency, and a latency of 0 clears it at once.
- R11: Countdowns keep decrementing during stall cycles, so a stall always ends exactly when the producing result is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented at decode |
| in_src_a | input | 5 | First source register index |
| in_src_b | input | 5 | Second source register index |
| in_dst | input | 5 | Destination register index |
| in_wr | input | 1 | Instruction writes `in_dst` |
| in_class | input | 2 | Execution class, selects the unit-occupancy countdown |
| in_lat | input | 7 | Extra result-latency cycles of this instruction |
| in_ivl | input | 7 | Cycles the class stays occupied after this issue |
| out_stall | output | 1 | Presented instruction must wait this cycle |
| out_issue | output | 1 | Presented instruction issues this cycle |

## Verification
The stall and issue flags are combinational on the current inputs and the countdown state, so they are due in the same cycle as the stimulus. Countdowns change only on the next rising edge. A write issued in cycle t therefore blocks its readers in cycles t+1 through t+L, and they issue in cycle t+L+1. The bench drives inputs just after the falling edge and samples one time unit later, so each check sees a settled cycle. It then advances a reference countdown model at the edge that follows. Directed cases count the stall cycles between presentation and issue and compare that count with the L - k + 1 and interval rules.

// File: rtl/hs_pkg.sv
package hs_pkg;
  // Default geometry of the scoreboard
  localparam int HS_NUM_REGS    = 32;
  localparam int HS_NUM_CLASSES = 4;
  localparam int HS_CNT_W       = 7;
endpackage

// File: rtl/hs_index_decode.sv
// Turns an index plus enable into a one-hot load vector.
module hs_index_decode #(
  parameter int N   = 32,
  parameter int IDW = $clog2(N)
) (
  input  logic           en,
  input  logic [IDW-1:0] idx,
  output logic [N-1:0]   onehot
);
  always_comb begin
    onehot = '0;
    for (int i = 0; i < N; i++) begin
      if (en && (idx == IDW'(i))) onehot[i] = 1'b1;
    end
  end
endmodule

// File: rtl/hs_countdown_bank.sv
// A bank of loadable countdowns; busy while the count is nonzero.
module hs_countdown_bank #(
  parameter int N = 32,
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] load_en,
  input  logic [W-1:0] load_val,
  output logic [N-1:0] busy
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;
    logic         cnt_en;

    always_comb begin
      cnt_d  = cnt_q;
      cnt_en = load_en[g] | (cnt_q != '0);
      if (load_en[g])          cnt_d = load_val;
      else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign busy[g] = (cnt_q != '0);
  end
endmodule

// File: rtl/hs_hazard_detect.sv
// Combinational stall decision from pending registers and busy classes.
module hs_hazard_detect #(
  parameter int NREG  = 32,
  parameter int NCLS  = 4,
  parameter int IDW   = $clog2(NREG),
  parameter int CLSW  = $clog2(NCLS)
) (
  input  logic             valid,
  input  logic [IDW-1:0]   src_a,
  input  logic [IDW-1:0]   src_b,
  input  logic [CLSW-1:0]  cls,
  input  logic [NREG-1:0]  reg_busy,
  input  logic [NCLS-1:0]  unit_busy,
  output logic             stall
);
  logic hit_a;
  logic hit_b;
  logic hit_unit;

  always_comb begin
    hit_a    = (src_a != '0) && reg_busy[src_a];
    hit_b    = (src_b != '0) && reg_busy[src_b];
    hit_unit = unit_busy[cls];
    stall    = valid && (hit_a || hit_b || hit_unit);
  end
endmodule

// File: rtl/hazard_scoreboard.sv
// Decode-stage interlock: per-register result countdowns and
// per-class issue-interval countdowns.
module hazard_scoreboard
  import hs_pkg::*;
#(
  parameter int NUM_REGS    = HS_NUM_REGS,
  parameter int NUM_CLASSES = HS_NUM_CLASSES,
  parameter int CNT_W       = HS_CNT_W,
  localparam int IDX_W      = $clog2(NUM_REGS),
  localparam int CLS_W      = $clog2(NUM_CLASSES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_src_a,
  input  logic [IDX_W-1:0] in_src_b,
  input  logic [IDX_W-1:0] in_dst,
  input  logic             in_wr,
  input  logic [CLS_W-1:0] in_class,
  input  logic [CNT_W-1:0] in_lat,
  input  logic [CNT_W-1:0] in_ivl,
  output logic             out_stall,
  output logic             out_issue
);
  logic [NUM_REGS-1:0]    reg_busy;
  logic [NUM_CLASSES-1:0] unit_busy;
  logic [NUM_REGS-1:0]    reg_load;
  logic [NUM_CLASSES-1:0] unit_load;
  logic                   stall_w;
  logic                   issue_w;
  logic                   reg_go;

  hs_hazard_detect #(
    .NREG(NUM_REGS), .NCLS(NUM_CLASSES), .IDW(IDX_W), .CLSW(CLS_W)
  ) u_detect (
    .valid    (in_valid),
    .src_a    (in_src_a),
    .src_b    (in_src_b),
    .cls      (in_class),
    .reg_busy (reg_busy),
    .unit_busy(unit_busy),
    .stall    (stall_w)
  );

  // Loads happen only on the issue cycle; index 0 is never tracked.
  assign issue_w = in_valid & ~stall_w;
  assign reg_go  = issue_w & in_wr & (in_dst != '0);

  hs_index_decode #(.N(NUM_REGS), .IDW(IDX_W)) u_reg_dec (
    .en(reg_go), .idx(in_dst), .onehot(reg_load)
  );

  hs_index_decode #(.N(NUM_CLASSES), .IDW(CLS_W)) u_cls_dec (
    .en(issue_w), .idx(in_class), .onehot(unit_load)
  );

  hs_countdown_bank #(.N(NUM_REGS), .W(CNT_W)) u_reg_bank (
    .clk(clk), .rst_n(rst_n),
    .load_en(reg_load), .load_val(in_lat), .busy(reg_busy)
  );

  hs_countdown_bank #(.N(NUM_CLASSES), .W(CNT_W)) u_unit_bank (
    .clk(clk), .rst_n(rst_n),
    .load_en(unit_load), .load_val(in_ivl), .busy(unit_busy)
  );

  assign out_stall = stall_w;
  assign out_issue = issue_w;
endmodule

// File: rtl/hs_checks.sv
module hs_checks #(
  parameter int NUM_REGS    = 32,
  parameter int NUM_CLASSES = 4,
  parameter int CNT_W       = 7,
  localparam int IDX_W      = $clog2(NUM_REGS),
  localparam int CLS_W      = $clog2(NUM_CLASSES)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [IDX_W-1:0]    in_src_a,
  input logic [IDX_W-1:0]    in_dst,
  input logic                in_wr,
  input logic [CLS_W-1:0]    in_class,
  input logic [CNT_W-1:0]    in_lat,
  input logic [CNT_W-1:0]    in_ivl,
  input logic                out_stall,
  input logic                out_issue,
  input logic [NUM_REGS-1:0] reg_busy
);
  // R2
  stall_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_stall |-> in_valid);

  // R2
  issue_excludes_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_issue && out_stall));

  // R4
  reader_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_issue && in_wr && (in_dst != '0) && (in_lat != '0)) |=>
      (!in_valid || (in_src_a != $past(in_dst)) || out_stall));

  // R5
  zero_reg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_busy[0]);

  // R8
  class_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_issue && (in_ivl != '0)) |=>
      (!in_valid || (in_class != $past(in_class)) || out_stall));

  // R9
  no_load_without_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(out_issue) |-> ((reg_busy & ~$past(reg_busy)) == '0));
endmodule

bind hazard_scoreboard hs_checks #(
  .NUM_REGS(NUM_REGS), .NUM_CLASSES(NUM_CLASSES), .CNT_W(CNT_W)
) u_hs_checks (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src_a(in_src_a),
  .in_dst(in_dst), .in_wr(in_wr), .in_class(in_class), .in_lat(in_lat),
  .in_ivl(in_ivl), .out_stall(out_stall), .out_issue(out_issue),
  .reg_busy(reg_busy)
);

// File: tb/test_hazard_scoreboard.sv
module test_hazard_scoreboard;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [4:0] in_src_a, in_src_b, in_dst;
  logic       in_wr;
  logic [1:0] in_class;
  logic [6:0] in_lat, in_ivl;
  logic       out_stall, out_issue;

  int n_tests = 0;
  int n_fail  = 0;
  int m_reg[32];
  int m_unit[4];
  bit done = 0;
  bit last_issue;

  hazard_scoreboard i_hazard_scoreboard (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src_a(in_src_a),
    .in_src_b(in_src_b), .in_dst(in_dst), .in_wr(in_wr), .in_class(in_class),
    .in_lat(in_lat), .in_ivl(in_ivl), .out_stall(out_stall), .out_issue(out_issue)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit pend(input logic [4:0] r);
    return (r != 5'd0) && (m_reg[r] != 0);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // At a falling edge with inputs set: check, then advance the model.
  task automatic step();
    bit es, ei;
    #1;
    es = in_valid && (pend(in_src_a) || pend(in_src_b) || (m_unit[in_class] != 0));
    ei = in_valid && !es;
    chk("R2 stall", out_stall, es);
    chk("R2 issue", out_issue, ei);
    for (int r = 0; r < 32; r++) if (m_reg[r] != 0) m_reg[r]--;
    for (int c = 0; c < 4; c++)  if (m_unit[c] != 0) m_unit[c]--;
    if (ei && in_wr && in_dst != 5'd0) m_reg[in_dst] = in_lat;
    if (ei) m_unit[in_class] = in_ivl;
    last_issue = ei;
    @(negedge clk);
  endtask

  task automatic send(input int a, input int b, input int d, input bit w,
                      input int c, input int l, input int iv, output int stalls);
    in_valid = 1'b1; in_src_a = 5'(a); in_src_b = 5'(b); in_dst = 5'(d);
    in_wr = w; in_class = 2'(c); in_lat = 7'(l); in_ivl = 7'(iv);
    stalls = 0;
    for (int g = 0; g < 300; g++) begin
      step();
      if (last_issue) break;
      stalls++;
    end
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) step();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++; n_tests++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int s;
    void'($urandom(32'd4711));
    foreach (m_reg[r]) m_reg[r] = 0;
    foreach (m_unit[c]) m_unit[c] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_src_a = '0; in_src_b = '0; in_dst = '0;
    in_wr = 1'b0; in_class = '0; in_lat = '0; in_ivl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reads of arbitrary registers issue at once after reset
    send(7, 31, 2, 1'b0, 1, 0, 0, s); chk("R1 first issue stalls", s, 0);

    // R4: latency-2 write read immediately -> 2 stalls
    send(2, 3, 1, 1'b1, 1, 2, 0, s);
    send(1, 0, 4, 1'b1, 0, 0, 0, s); chk("R4 immediate consumer", s, 2);
    idle(8);
    // R7 / R4: two independent instructions between -> no stall
    send(2, 3, 1, 1'b1, 1, 2, 0, s);
    send(5, 6, 5, 1'b1, 0, 0, 0, s); chk("R7 independent 1", s, 0);
    send(7, 8, 7, 1'b1, 0, 0, 0, s); chk("R7 independent 2", s, 0);
    send(1, 0, 1, 1'b1, 0, 0, 0, s); chk("R4 consumer after two", s, 0);
    idle(8);
    // R4: latency 3, consumer presented k=2 -> 2 stalls
    send(0, 0, 9, 1'b1, 1, 3, 0, s);
    send(4, 4, 4, 1'b1, 0, 0, 0, s);
    send(9, 0, 2, 1'b1, 0, 0, 0, s); chk("R4 partial latency", s, 2);
    idle(8);
    // R3: zero latency -> next reader issues
    send(0, 0, 3, 1'b1, 0, 0, 0, s);
    send(3, 3, 4, 1'b1, 0, 0, 0, s); chk("R3 zero latency", s, 0);
    idle(8);
    // R6: dependency through source B, latency 4
    send(0, 0, 12, 1'b1, 1, 4, 0, s);
    send(1, 12, 13, 1'b1, 0, 0, 0, s); chk("R6 source B", s, 4);
    idle(8);
    // R5: writes to register 0 are not tracked
    send(0, 0, 0, 1'b1, 1, 5, 0, s);
    send(0, 0, 14, 1'b1, 0, 0, 0, s); chk("R5 reg zero", s, 0);
    idle(8);
    // R8: class 2 interval 3 blocks class 2, not class 1
    send(0, 0, 15, 1'b1, 2, 5, 3, s);
    send(1, 2, 16, 1'b1, 1, 0, 0, s); chk("R8 other class", s, 0);
    send(1, 2, 17, 1'b1, 2, 0, 0, s); chk("R8 same class", s, 2);
    idle(10);
    send(0, 0, 15, 1'b1, 2, 0, 3, s);
    send(1, 2, 17, 1'b1, 2, 0, 0, s); chk("R8 same class immediate", s, 3);
    idle(10);
    // R9 / R11: stalled writer's latency counts from its own issue
    send(0, 0, 1, 1'b1, 1, 2, 0, s);
    send(1, 0, 9, 1'b1, 0, 3, 0, s); chk("R11 stall releases on time", s, 2);
    send(9, 0, 2, 1'b1, 0, 0, 0, s); chk("R9 load at issue", s, 3);
    idle(8);
    // R10: replacement with 0 clears, with larger value extends
    send(0, 0, 7, 1'b1, 1, 6, 0, s);
    send(0, 0, 7, 1'b1, 0, 0, 0, s);
    send(7, 0, 3, 1'b1, 0, 0, 0, s); chk("R10 cleared", s, 0);
    send(0, 0, 8, 1'b1, 1, 1, 0, s);
    send(0, 0, 8, 1'b1, 1, 5, 0, s);
    send(8, 0, 3, 1'b1, 0, 0, 0, s); chk("R10 replaced", s, 5);
    idle(8);

    // Random stream, checked each cycle against the model (R2, R4, R7, R8)
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 5) == 0) idle(1 + ($urandom % 3));
      else begin
        int c = $urandom % 4;
        send($urandom % 8, $urandom % 8, $urandom % 8, 1'($urandom % 2), c,
             (c == 0) ? 0 : ($urandom % 7), (c == 0) ? 0 : ($urandom % 4), s);
      end
    end
    idle(4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule